// File: doc/BRIEF.md
# Float Min Max Magnitude Unit

This unit takes two single-precision operands and a two-bit operation code, then chooses one of the operands and returns it unchanged. It never performs arithmetic and raises no flags. Four choices are offered: the signed smaller value, the signed larger value, the operand with the smaller magnitude, and the operand with the larger magnitude.

A NaN never wins against a number: if only one operand is a NaN, the other operand is returned. Equal magnitudes resolve toward the signed-larger operand. Positive zero and negative zero compare as equal.

The unit has one register stage, with a valid/ready handshake on both sides. An input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. The result is offered one cycle later. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When `out_ready` is high, a new input can be accepted in the same cycle that the current result leaves.

Top module: `fmm_unit`

## Requirements
- R1: Each accepted input yields, one clock later, `out_valid` high with `out_result` bit-for-bit equal to `in_a` or `in_b`.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold, and any offered input is not taken.
- R3: A NaN has exponent bits [30:23] all ones and mantissa bits [22:0] nonzero. When both operands are NaN, the result is `in_a`, whatever the operation.
- R4: When exactly one operand is NaN, the result is the other operand, whatever the operation. Infinity is not a NaN.
- R5: Op 0 (smaller) returns `in_b` when `in_a` is greater than or equal to `in_b`, and `in_a` otherwise.
- R6: Op 1 (larger) returns `in_b` when `in_a` is less than or equal to `in_b`, and `in_a` otherwise.
- R7: Op 2 (smaller magnitude) returns the operand whose absolute value is smaller.
- R8: Op 3 (larger magnitude) returns the operand whose absolute value is larger.
- R9: For ops 2 and 3, equal magnitudes return the signed-larger operand. When the two are also equal as signed values, `in_b` is returned.
- R10: +0 and -0 compare as equal, so ops 0 and 1 between zeros of opposite sign return `in_b`.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 2 | 0 smaller, 1 larger, 2 smaller magnitude, 3 larger magnitude |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Selected operand |

## Verification
Each operation is tried with operands of both signs, so that the signed order and the magnitude order disagree. A correct magnitude choice then cannot pass for a correct signed choice. Pairs of equal magnitude and opposite sign, and pairs of opposite-signed zeros, separate the tie rule from the plain ordering. Cases with one NaN, with two NaNs, and with an infinity separate NaN detection from the all-ones exponent alone. A stalled consumer with a competing input checks that back-pressure holds the result.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int EXP_W_DEF = 8;
  localparam int MAN_W_DEF = 23;

  typedef enum logic [1:0] {
    OP_MIN     = 2'd0,
    OP_MAX     = 2'd1,
    OP_MIN_MAG = 2'd2,
    OP_MAX_MAG = 2'd3
  } fmm_op_e;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] value,
  output logic         is_nan,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f  = value[W-2 -: EXP_W];
  assign man_f  = value[MAN_W-1:0];
  assign is_nan = (&exp_f) && (|man_f);
  assign mag    = value[W-2:0];
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-2:0] mag_a,
  input  logic [W-2:0] mag_b,
  output logic         a_lt_b,
  output logic         a_eq_b,
  output logic         mag_a_lt,
  output logic         mag_a_gt
);
  logic         zeros;
  logic [W-1:0] key_a, key_b;

  // Map sign-magnitude to an unsigned order key.
  assign key_a = a[W-1] ? ~a : (a ^ {1'b1, {(W-1){1'b0}}});
  assign key_b = b[W-1] ? ~b : (b ^ {1'b1, {(W-1){1'b0}}});
  assign zeros = (mag_a == '0) && (mag_b == '0);

  assign a_eq_b   = zeros || (a == b);
  assign a_lt_b   = !zeros && (key_a < key_b);
  assign mag_a_lt = mag_a < mag_b;
  assign mag_a_gt = mag_a > mag_b;
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
  import fmm_pkg::*;
(
  input  logic [1:0] op,
  input  logic       nan_a,
  input  logic       nan_b,
  input  logic       a_lt_b,
  input  logic       a_eq_b,
  input  logic       mag_a_lt,
  input  logic       mag_a_gt,
  output logic       take_b
);
  logic not_gt;

  assign not_gt = a_lt_b || a_eq_b;

  always_comb begin
    if (nan_a && nan_b)      take_b = 1'b0;
    else if (nan_a)          take_b = 1'b1;
    else if (nan_b)          take_b = 1'b0;
    else begin
      unique case (fmm_op_e'(op))
        OP_MIN:     take_b = !a_lt_b;
        OP_MAX:     take_b = not_gt;
        OP_MIN_MAG: take_b = mag_a_gt ? 1'b1 : (mag_a_lt ? 1'b0 : not_gt);
        OP_MAX_MAG: take_b = mag_a_lt ? 1'b1 : (mag_a_gt ? 1'b0 : not_gt);
        default:    take_b = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W = EXP_W_DEF,
  parameter int MAN_W = MAN_W_DEF,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result
);
  logic [W-1:0] opnd [2];
  logic         nan  [2];
  logic [W-2:0] mag  [2];
  logic a_lt_b, a_eq_b, mag_a_lt, mag_a_gt, take_b;
  logic [W-1:0] chosen;

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .value(opnd[i]), .is_nan(nan[i]), .mag(mag[i])
    );
  end

  fmm_order #(.W(W)) u_ord (
    .a(in_a), .b(in_b), .mag_a(mag[0]), .mag_b(mag[1]),
    .a_lt_b(a_lt_b), .a_eq_b(a_eq_b),
    .mag_a_lt(mag_a_lt), .mag_a_gt(mag_a_gt)
  );

  fmm_pick u_pick (
    .op(in_op), .nan_a(nan[0]), .nan_b(nan[1]),
    .a_lt_b(a_lt_b), .a_eq_b(a_eq_b),
    .mag_a_lt(mag_a_lt), .mag_a_gt(mag_a_gt), .take_b(take_b)
  );

  assign chosen   = take_b ? in_b : in_a;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_result <= chosen;
    end
  end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result
);
  logic a_nan, b_nan, take;
  assign a_nan = (in_a[W-2 -: EXP_W] == '1) && (in_a[MAN_W-1:0] != '0);
  assign b_nan = (in_b[W-2 -: EXP_W] == '1) && (in_b[MAN_W-1:0] != '0);
  assign take  = in_valid && in_ready;

  AST_PICKS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && (out_result == $past(in_a) || out_result == $past(in_b))); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_result)); // R2
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R2
  AST_BOTH_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && a_nan && b_nan) |=> out_result == $past(in_a)); // R3
  AST_ONE_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && a_nan && !b_nan) |=> out_result == $past(in_b)); // R4
endmodule

bind fmm_unit fmm_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result)
);

// File: tb/fmm_unit_test.sv
module fmm_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // {req, op, a, b, expected}
  localparam logic [103:0] VEC [NV] = '{
    {8'd3,  2'd0, 32'h7FC00000, 32'h7F800001, 32'h7FC00000}, // R3
    {8'd3,  2'd3, 32'hFF800001, 32'h7FC00000, 32'hFF800001}, // R3
    {8'd4,  2'd1, 32'h7FC00000, 32'h40000000, 32'h40000000}, // R4
    {8'd4,  2'd2, 32'hBF800000, 32'h7FC00000, 32'hBF800000}, // R4
    {8'd4,  2'd0, 32'h7F800000, 32'h3F800000, 32'h3F800000}, // R4 infinity
    {8'd5,  2'd0, 32'h3F800000, 32'h40000000, 32'h3F800000}, // R5
    {8'd5,  2'd0, 32'h40000000, 32'hC0400000, 32'hC0400000}, // R5
    {8'd5,  2'd0, 32'hBF800000, 32'hC0000000, 32'hC0000000}, // R5
    {8'd6,  2'd1, 32'h3F800000, 32'h40000000, 32'h40000000}, // R6
    {8'd6,  2'd1, 32'hBF800000, 32'hC0000000, 32'hBF800000}, // R6
    {8'd6,  2'd1, 32'hFF800000, 32'hC0400000, 32'hC0400000}, // R6
    {8'd7,  2'd2, 32'hC0400000, 32'h40000000, 32'h40000000}, // R7
    {8'd7,  2'd2, 32'h3F800000, 32'hC0000000, 32'h3F800000}, // R7
    {8'd8,  2'd3, 32'hC0400000, 32'h40000000, 32'hC0400000}, // R8
    {8'd8,  2'd3, 32'h3F800000, 32'hC0000000, 32'hC0000000}, // R8
    {8'd9,  2'd2, 32'hC0000000, 32'h40000000, 32'h40000000}, // R9
    {8'd9,  2'd3, 32'h40000000, 32'hC0000000, 32'h40000000}, // R9
    {8'd9,  2'd2, 32'h40400000, 32'hC0400000, 32'h40400000}, // R9
    {8'd10, 2'd0, 32'h00000000, 32'h80000000, 32'h80000000}, // R10
    {8'd10, 2'd1, 32'h80000000, 32'h00000000, 32'h00000000}, // R10
    {8'd10, 2'd0, 32'h80000000, 32'h00000000, 32'h00000000}, // R10
    {8'd9,  2'd3, 32'h00000000, 32'h80000000, 32'h80000000}  // R9 zero tie
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_op = '0;
  logic in_ready, out_valid;
  logic [31:0] out_result;
  int n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      in_op = VEC[i][97:96]; in_a = VEC[i][95:64]; in_b = VEC[i][63:32];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1 valid vec%0d", i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R%0d vec%0d", VEC[i][103:96] >> 2, i), out_result, VEC[i][31:0]);
    end

    // R2 back-pressure: stalled output holds, competing input waits
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 2'd0; in_a = 32'h3F800000; in_b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk);
    check("R2 stalled result", out_result, 32'h3F800000);
    check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    in_a = 32'hC0400000; in_b = 32'h40000000;
    @(negedge clk);
    check("R2 result held", out_result, 32'h3F800000);
    check("R2 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next result after release", out_result, 32'hC0400000);
    @(negedge clk);
    check("R2 drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule